// File: doc/BRIEF.md
# Stereo DC-Offset Removal Filter with Hold

This block follows the decimation stage of a two-channel audio converter. For each channel it keeps a running estimate of the DC level, held in a fixed-point accumulator. On every sample strobe it subtracts the integer part of that estimate from the incoming 24-bit two's-complement sample. The result is a first-order high-pass response. The estimate moves toward the current sample by a power-of-two fraction of the gap on each strobe. With the default shift of 13 the -3 dB corner lies near 0.93 Hz at a 48 kHz sample rate, and the corner scales in proportion to the sample rate.

A hold input stops the estimate from changing. The value already learned is still subtracted from every sample. This supports a system offset calibration. First run with tracking on until the estimate settles, then assert hold. The learned offset of the whole signal chain ahead of the block is then removed as a fixed constant.

Each corrected sample appears one clock after its input strobe, together with an output strobe. The difference is clipped to the sample range, so it never wraps.

Top module: `dc_trim_filter`

## Requirements
- R1: While reset is active, and after reset, both outputs read zero, the output strobe is low and both offset estimates are zero. The first strobed sample after reset is therefore passed through unchanged.
- R2: The output strobe follows the input strobe with exactly one clock of delay. The corrected outputs change only in the cycle after a strobed input and hold their value otherwise.
- R3: For a strobed sample x, the output is x minus off, where off is the estimate before that sample's update taken as floor(acc / 2^FRAC_W). The accumulator acc carries FRAC_W fraction bits.
- R4: On a strobed sample with hold low, the accumulator becomes acc + floor((x*2^FRAC_W - acc) / 2^SHIFT).
- R5: While hold is high, the accumulator keeps its value across strobes, and the held offset is still subtracted from each strobed sample.
- R6: The difference is clipped to the signed range -2^(DATA_W-1) .. 2^(DATA_W-1)-1 instead of wrapping.
- R7: The left and right channels keep separate estimates. Samples on one channel never change the other channel's output.
- R8: Cycles without an input strobe leave both estimates unchanged, whatever the sample inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld_i | input | 1 | Sample strobe for both channels |
| smp_l_i | input | DATA_W | Left sample, two's complement |
| smp_r_i | input | DATA_W | Right sample, two's complement |
| freeze_i | input | 1 | High holds both offset estimates |
| out_vld_o | output | 1 | Corrected-sample strobe |
| out_l_o | output | DATA_W | Corrected left sample |
| out_r_o | output | DATA_W | Corrected right sample |

## Verification
The bench reduces the configuration to 8-bit samples, 4 fraction bits and a shift of 3, so every input code can be swept on both channels. It uses the following patterns:
- A constant DC level shows the estimate converging according to the update rule.
- A full ascending sweep on the left, run against a descending sweep on the right, covers every code while tracking.
- A full sweep with hold applied after learning opposite-signed offsets on the two channels drives the difference into both clip limits and shows the offset kept constant.
- Idle cycles carrying junk data, and a one-sided stimulus, separate a correct design from ones that update without a strobe or couple the channels.

// File: rtl/dctrim_pkg.sv
package dctrim_pkg;
  localparam int DEF_DATA_W = 24;
  localparam int DEF_FRAC_W = 16;
  localparam int DEF_SHIFT  = 13;
  localparam int NUM_CH     = 2;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/dctrim_tracker.sv
module dctrim_tracker #(
  parameter int DATA_W = 24,
  parameter int FRAC_W = 16,
  parameter int SHIFT  = 13
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic                     freeze_i,
  input  logic signed [DATA_W-1:0] smp_i,
  output logic signed [DATA_W-1:0] off_o
);
  localparam int ACC_W = DATA_W + FRAC_W;

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W-1:0] target;
  logic signed [ACC_W:0]   gap;
  logic signed [ACC_W:0]   step;
  logic                    upd_en;

  always_comb begin
    target = {smp_i, {FRAC_W{1'b0}}};
    gap    = {target[ACC_W-1], target} - {acc_q[ACC_W-1], acc_q};
    step   = gap >>> SHIFT;
    upd_en = vld_i & ~freeze_i;
    acc_d  = acc_q;
    if (upd_en) acc_d = acc_q + step[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign off_o = acc_q[ACC_W-1:FRAC_W];

  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(off_o)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(off_o)); // R8
endmodule

// File: rtl/dctrim_sub.sv
module dctrim_sub #(
  parameter int DATA_W = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic signed [DATA_W-1:0] smp_i,
  input  logic signed [DATA_W-1:0] off_i,
  output logic signed [DATA_W-1:0] out_o
);
  localparam logic signed [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W:0]   diff;
  logic signed [DATA_W-1:0] clip;
  logic signed [DATA_W-1:0] out_q, out_d;

  always_comb begin
    diff = {smp_i[DATA_W-1], smp_i} - {off_i[DATA_W-1], off_i};
    if (diff[DATA_W] != diff[DATA_W-1]) clip = diff[DATA_W] ? S_MIN : S_MAX;
    else                                clip = diff[DATA_W-1:0];
    out_d = vld_i ? clip : out_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  assign out_o = out_q;

  AST_PASS_ZERO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && off_i == '0) |=> out_o == $past(smp_i)); // R3
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(out_o)); // R2
endmodule

// File: rtl/dc_trim_filter.sv
module dc_trim_filter
  import dctrim_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int FRAC_W = DEF_FRAC_W,
  parameter int SHIFT  = DEF_SHIFT
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smp_vld_i,
  input  logic signed [DATA_W-1:0] smp_l_i,
  input  logic signed [DATA_W-1:0] smp_r_i,
  input  logic                     freeze_i,
  output logic                     out_vld_o,
  output logic signed [DATA_W-1:0] out_l_o,
  output logic signed [DATA_W-1:0] out_r_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic signed [DATA_W-1:0] smp_a [NUM_CH];
  logic signed [DATA_W-1:0] off_a [NUM_CH];
  logic signed [DATA_W-1:0] out_a [NUM_CH];

  assign smp_a[CH_LEFT]  = smp_l_i;
  assign smp_a[CH_RIGHT] = smp_r_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dctrim_tracker #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .SHIFT(SHIFT)) u_trk (
      .clk_i    (clk_i),
      .rst_ni   (rst_n_int),
      .vld_i    (smp_vld_i),
      .freeze_i (freeze_i),
      .smp_i    (smp_a[c]),
      .off_o    (off_a[c])
    );
    dctrim_sub #(.DATA_W(DATA_W)) u_sub (
      .clk_i  (clk_i),
      .rst_ni (rst_n_int),
      .vld_i  (smp_vld_i),
      .smp_i  (smp_a[c]),
      .off_i  (off_a[c]),
      .out_o  (out_a[c])
    );
  end

  logic vld_q, vld_d;
  always_comb vld_d = smp_vld_i;
  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) vld_q <= 1'b0;
    else            vld_q <= vld_d;
  end

  assign out_vld_o = vld_q;
  assign out_l_o   = out_a[CH_LEFT];
  assign out_r_o   = out_a[CH_RIGHT];

  AST_CHANGE_NEEDS_STROBE_L: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !$stable(out_l_o) |-> out_vld_o); // R2
  AST_CHANGE_NEEDS_STROBE_R: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !$stable(out_r_o) |-> out_vld_o); // R2
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_n_int |-> (!out_vld_o && out_l_o == '0 && out_r_o == '0)); // R1
endmodule

// File: tb/dc_trim_filter_tb.sv
module dc_trim_filter_tb;
  localparam int  DW = 8;
  localparam int  FW = 4;
  localparam int  SH = 3;
  localparam time CLK_PERIOD = 10ns;
  localparam longint SMAX = (1 <<< (DW-1)) - 1;
  localparam longint SMIN = -(1 <<< (DW-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic frz = 1'b0;
  logic signed [DW-1:0] sl = '0, sr = '0;
  logic out_vld;
  logic signed [DW-1:0] ol, orr;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  longint accl = 0, accr = 0, expl = 0, expr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dc_trim_filter #(.DATA_W(DW), .FRAC_W(FW), .SHIFT(SH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .smp_l_i(sl), .smp_r_i(sr),
    .freeze_i(frz), .out_vld_o(out_vld), .out_l_o(ol), .out_r_o(orr)
  );

  function automatic longint sat(input longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Drive at a falling edge, check at the next falling edge.
  task automatic cyc(input longint l, input longint r, input bit v, input bit f, input string tag);
    sl = l[DW-1:0]; sr = r[DW-1:0]; vld = v; frz = f;
    if (v) begin
      expl = sat(l - (accl >>> FW));
      expr = sat(r - (accr >>> FW));
      if (!f) begin
        accl = accl + (((l <<< FW) - accl) >>> SH);
        accr = accr + (((r <<< FW) - accr) >>> SH);
      end
    end
    @(negedge clk);
    chk(tag, "strobe", longint'(out_vld), longint'(v));
    chk(tag, "left", longint'(ol), expl);
    chk(tag, "right", longint'(orr), expr);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; vld = 1'b0; frz = 1'b0;
    @(negedge clk);
    chk("R1", "strobe in reset", longint'(out_vld), 0);
    chk("R1", "left in reset", longint'(ol), 0);
    chk("R1", "right in reset", longint'(orr), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    accl = 0; accr = 0; expl = 0; expr = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1: first sample passes unchanged
    cyc(77, -91, 1'b1, 1'b0, "R1");
    do_reset();
    // R4: constant DC converges per update rule
    for (int i = 0; i < 40; i++) cyc(100, -50, 1'b1, 1'b0, "R4");
    chk("R4", "left decayed", longint'(ol < 100), 1);
    // R3/R6: full sweep while tracking, left up and right down
    for (int i = 0; i < 256; i++) cyc(SMIN + i, SMAX - i, 1'b1, 1'b0, "R3");
    // R8: idle cycles with junk data, then a strobe reveals untouched estimate
    for (int i = 0; i < 10; i++) cyc(SMAX - 3*i, SMIN + 5*i, 1'b0, 1'b0, "R8");
    cyc(5, -5, 1'b1, 1'b0, "R8");
    // R5/R6: learn opposite offsets, then hold and sweep every code
    for (int i = 0; i < 60; i++) cyc(60, -60, 1'b1, 1'b0, "R5");
    for (int i = 0; i < 256; i++) cyc(SMIN + i, SMIN + i, 1'b1, 1'b1, "R6");
    for (int i = 0; i < 20; i++) cyc(SMAX, SMIN, 1'b1, 1'b1, "R5");
    // R2: idle while held, outputs keep last value
    for (int i = 0; i < 5; i++) cyc(i, -i, 1'b0, 1'b1, "R2");
    // release hold, tracking resumes
    for (int i = 0; i < 20; i++) cyc(-20, 20, 1'b1, 1'b0, "R4");
    // R7: only left varies, right stays at zero with zero estimate
    do_reset();
    for (int i = 0; i < 64; i++) cyc(4*i - 128, 0, 1'b1, 1'b0, "R7");
    chk("R7", "right untouched", longint'(orr), 0);
    // R1: reset mid-run clears state
    do_reset();
    cyc(-33, 44, 1'b1, 1'b0, "R1");
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule